// File: doc/BRIEF.md
# Next-Frame Active Phone List Merger

This block assembles the list of phones that a speech decoder must score in the coming frame. Two request streams feed it. The scorer stream carries phones that survived pruning and stay alive. The grammar stream carries phones that start fresh because a predecessor is likely to have ended, each with an entry score. Either stream may name the same phone more than once in a frame, and both may name the same phone. The block keeps one list record per phone id, holding the best (numerically lowest) start score seen for it.

A frame begins with a pulse on `frame_start`. A sweep then clears the per-id lookup table, and both inputs are held off until it finishes. Requests are then accepted with valid/ready handshakes. A new id takes the next free list slot, in acceptance order. A repeat id rewrites the score of its existing slot only when the new score is strictly smaller. Each stream closes with an end pulse. Once both streams have closed and the last accepted request has been applied, `done` rises and `count` holds the number of list entries. The list is read back through a synchronous read port, which the next frame's scorer uses.

Top module: `active_list_merger`

## Requirements
- R1: After reset, `done` is 0, `count` is 0, and both `vit_ready` and `gr_ready` are 0 until a `frame_start` pulse.
- R2: After `frame_start` is sampled, both ready outputs stay low for exactly 2^ID_W cycles, which clear the table. Both then rise.
- R3: Each distinct phone id accepted in a frame gets one list slot. Slots are assigned 0, 1, 2, ... in acceptance order and store that id and its score. `count` rises by at most one per cycle.
- R4: When an id already in the list is accepted again from either stream, its slot keeps its position. The stored score is replaced only when the new score is strictly smaller, with lower meaning better.
- R5: When both streams present a request in the same cycle, the scorer request is accepted and `gr_ready` is 0 in that cycle. The grammar request is taken in a later cycle.
- R6: Repeats of one id that are accepted in consecutive cycles are merged exactly as if they were spaced apart.
- R7: After a stream's end pulse, that stream's ready stays 0. Once both end pulses are seen and every accepted request has been applied, `done` becomes 1 and `count` equals the number of entries. Both stay unchanged, with both readies low, until the next `frame_start`.
- R8: `count` never exceeds LIST_DEPTH. When the list is full, new ids are dropped, while score improvements to ids already listed still apply.
- R9: A `frame_start` discards the previous frame's membership, so an id listed in an earlier frame is treated as new.
- R10: `rd_id` and `rd_score` show the contents of slot `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: begin building a new list |
| vit_valid | input | 1 | Scorer stream request valid |
| vit_ready | output | 1 | Scorer stream request accepted |
| vit_id | input | ID_W | Scorer phone id |
| vit_score | input | SC_W | Scorer start score (lower is better) |
| vit_end | input | 1 | Pulse: scorer stream finished for this frame |
| gr_valid | input | 1 | Grammar stream request valid |
| gr_ready | output | 1 | Grammar stream request accepted |
| gr_id | input | ID_W | Grammar phone id |
| gr_score | input | SC_W | Grammar entry score (lower is better) |
| gr_end | input | 1 | Pulse: grammar stream finished for this frame |
| rd_addr | input | $clog2(LIST_DEPTH) | List slot to read |
| rd_id | output | ID_W | Phone id stored in the slot read |
| rd_score | output | SC_W | Best score stored in the slot read |
| done | output | 1 | List complete for this frame |
| count | output | $clog2(LIST_DEPTH+1) | Number of list entries |

## Verification
The assertions check on every cycle the properties that appear at the ports. They cover the blocked inputs during the sweep and the scorer-first arbitration. They also cover the count bound and its single-step growth, and the frozen `done` and `count` with both streams closed. The merge itself needs the bench's scenarios, read back through the list port: minimum-score retention, slot order, merging of back-to-back repeats, dropping of new ids at a full list, and forgetting of ids across frames. Only those scenarios show that the right id and score reached the right slot.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } merge_state_t;
endpackage

// File: rtl/merge_arbiter.sv
module merge_arbiter #(
  parameter int ID_W = 8,
  parameter int SC_W = 16
) (
  input  logic            run,
  input  logic            vit_open,
  input  logic            gr_open,
  input  logic            vit_valid,
  input  logic [ID_W-1:0] vit_id,
  input  logic [SC_W-1:0] vit_score,
  input  logic            gr_valid,
  input  logic [ID_W-1:0] gr_id,
  input  logic [SC_W-1:0] gr_score,
  output logic            vit_ready,
  output logic            gr_ready,
  output logic            acc_valid,
  output logic [ID_W-1:0] acc_id,
  output logic [SC_W-1:0] acc_score
);
  logic vit_take;
  logic gr_take;

  always_comb begin
    vit_ready = run && vit_open;
    vit_take  = vit_ready && vit_valid;
    // scorer stream has fixed priority
    gr_ready  = run && gr_open && !vit_take;
    gr_take   = gr_ready && gr_valid;
    acc_valid = vit_take || gr_take;
    acc_id    = vit_take ? vit_id : gr_id;
    acc_score = vit_take ? vit_score : gr_score;
  end
endmodule

// File: rtl/merge_table.sv
module merge_table #(
  parameter int ID_W  = 8,
  parameter int ENT_W = 23
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ID_W-1:0]  waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [ID_W-1:0]  raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int N = 1 << ID_W;

  logic [ENT_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/merge_list_mem.sv
module merge_list_mem #(
  parameter int DEPTH = 64,
  parameter int ID_W  = 8,
  parameter int SC_W  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [ID_W-1:0] wid,
  input  logic [SC_W-1:0] wscore,
  input  logic [AW-1:0]   raddr,
  output logic [ID_W-1:0] rid,
  output logic [SC_W-1:0] rscore
);
  logic [ID_W-1:0] id_mem [DEPTH];
  logic [SC_W-1:0] sc_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      id_mem[waddr] <= wid;
      sc_mem[waddr] <= wscore;
    end
    rid    <= id_mem[raddr];
    rscore <= sc_mem[raddr];
  end
endmodule

// File: rtl/active_list_merger.sv
module active_list_merger #(
  parameter int ID_W       = 8,
  parameter int SC_W       = 16,
  parameter int LIST_DEPTH = 64,
  localparam int SLOT_W    = $clog2(LIST_DEPTH),
  localparam int CNT_W     = $clog2(LIST_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              vit_valid,
  output logic              vit_ready,
  input  logic [ID_W-1:0]   vit_id,
  input  logic [SC_W-1:0]   vit_score,
  input  logic              vit_end,
  input  logic              gr_valid,
  output logic              gr_ready,
  input  logic [ID_W-1:0]   gr_id,
  input  logic [SC_W-1:0]   gr_score,
  input  logic              gr_end,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic [ID_W-1:0]   rd_id,
  output logic [SC_W-1:0]   rd_score,
  output logic              done,
  output logic [CNT_W-1:0]  count
);
  import merge_pkg::*;

  localparam int ENT_W = 1 + SLOT_W + SC_W;
  localparam logic [ID_W-1:0]  SWEEP_LAST = {ID_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(LIST_DEPTH);

  merge_state_t      state;
  logic [ID_W-1:0]   sweep_addr;
  logic              vit_closed, gr_closed;
  logic              s1_valid;
  logic [ID_W-1:0]   s1_id;
  logic [SC_W-1:0]   s1_score;
  logic              fwd_valid;
  logic [ID_W-1:0]   fwd_id;
  logic [ENT_W-1:0]  fwd_ent;
  logic [CNT_W-1:0]  cnt;
  logic              done_q;

  logic              acc_valid;
  logic [ID_W-1:0]   acc_id;
  logic [SC_W-1:0]   acc_score;
  logic [ENT_W-1:0]  tbl_rdata;
  logic              tbl_we;
  logic [ID_W-1:0]   tbl_waddr;
  logic [ENT_W-1:0]  tbl_wdata;

  logic [ENT_W-1:0]  cur;
  logic              cur_v;
  logic [SLOT_W-1:0] cur_slot;
  logic [SC_W-1:0]   cur_sc;
  logic              is_new, is_better, upd_we;
  logic [SLOT_W-1:0] upd_slot;
  logic [ENT_W-1:0]  upd_ent;

  merge_arbiter #(.ID_W(ID_W), .SC_W(SC_W)) u_arb (
    .run       (state == ST_RUN),
    .vit_open  (!vit_closed),
    .gr_open   (!gr_closed),
    .vit_valid (vit_valid),
    .vit_id    (vit_id),
    .vit_score (vit_score),
    .gr_valid  (gr_valid),
    .gr_id     (gr_id),
    .gr_score  (gr_score),
    .vit_ready (vit_ready),
    .gr_ready  (gr_ready),
    .acc_valid (acc_valid),
    .acc_id    (acc_id),
    .acc_score (acc_score)
  );

  merge_table #(.ID_W(ID_W), .ENT_W(ENT_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (acc_id),
    .rdata (tbl_rdata)
  );

  merge_list_mem #(.DEPTH(LIST_DEPTH), .ID_W(ID_W), .SC_W(SC_W)) u_list (
    .clk    (clk),
    .we     (upd_we),
    .waddr  (upd_slot),
    .wid    (s1_id),
    .wscore (s1_score),
    .raddr  (rd_addr),
    .rid    (rd_id),
    .rscore (rd_score)
  );

  // merge decision for the request read out of the table last cycle
  always_comb begin
    // the previous write lands on the same edge as this read: forward it
    cur       = (fwd_valid && fwd_id == s1_id) ? fwd_ent : tbl_rdata;
    cur_v     = cur[ENT_W-1];
    cur_slot  = cur[SC_W +: SLOT_W];
    cur_sc    = cur[SC_W-1:0];
    is_new    = s1_valid && !cur_v && (cnt < CNT_FULL);
    is_better = s1_valid && cur_v && (s1_score < cur_sc);
    upd_we    = is_new || is_better;
    upd_slot  = is_new ? cnt[SLOT_W-1:0] : cur_slot;
    upd_ent   = {1'b1, upd_slot, s1_score};
    if (state == ST_CLEAR) begin
      tbl_we    = 1'b1;
      tbl_waddr = sweep_addr;
      tbl_wdata = '0;
    end else begin
      tbl_we    = upd_we;
      tbl_waddr = s1_id;
      tbl_wdata = upd_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sweep_addr <= '0;
      vit_closed <= 1'b0;
      gr_closed  <= 1'b0;
      s1_valid   <= 1'b0;
      s1_id      <= '0;
      s1_score   <= '0;
      fwd_valid  <= 1'b0;
      fwd_id     <= '0;
      fwd_ent    <= '0;
      cnt        <= '0;
      done_q     <= 1'b0;
    end else if (frame_start) begin
      state      <= ST_CLEAR;
      sweep_addr <= '0;
      vit_closed <= 1'b0;
      gr_closed  <= 1'b0;
      s1_valid   <= 1'b0;
      fwd_valid  <= 1'b0;
      cnt        <= '0;
      done_q     <= 1'b0;
    end else begin
      s1_valid  <= acc_valid;
      s1_id     <= acc_id;
      s1_score  <= acc_score;
      fwd_valid <= upd_we;
      fwd_id    <= s1_id;
      fwd_ent   <= upd_ent;
      if (is_new) cnt <= cnt + 1'b1;
      case (state)
        ST_CLEAR: begin
          sweep_addr <= sweep_addr + 1'b1;
          if (sweep_addr == SWEEP_LAST) state <= ST_RUN;
        end
        ST_RUN: begin
          if (vit_end) vit_closed <= 1'b1;
          if (gr_end)  gr_closed  <= 1'b1;
          if (vit_closed && gr_closed && !s1_valid && !acc_valid) begin
            state  <= ST_DONE;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done  = done_q;
  assign count = cnt;
endmodule

// File: rtl/merge_checker.sv
module merge_checker #(
  parameter int LIST_DEPTH = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             vit_valid,
  input logic             vit_ready,
  input logic             gr_ready,
  input logic             done,
  input logic [CNT_W-1:0] count
);
  assert_sweep_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!vit_ready && !gr_ready));

  assert_scorer_first_R5: assert property (@(posedge clk) disable iff (rst)
    (vit_valid && vit_ready) |-> !gr_ready);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(LIST_DEPTH));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !frame_start) |=> (done && $stable(count)));

  assert_done_closed_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!vit_ready && !gr_ready));
endmodule

bind active_list_merger merge_checker #(
  .LIST_DEPTH (LIST_DEPTH),
  .CNT_W      (CNT_W)
) i_merge_checker (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .vit_valid   (vit_valid),
  .vit_ready   (vit_ready),
  .gr_ready    (gr_ready),
  .done        (done),
  .count       (count)
);

// File: tb/test_active_list_merger.sv
`timescale 1ns/1ps
module test_active_list_merger;
  localparam int ID_W = 8;
  localparam int SC_W = 16;
  localparam int DEPTH = 64;
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic vit_valid = 1'b0, gr_valid = 1'b0;
  logic vit_end = 1'b0, gr_end = 1'b0;
  logic [ID_W-1:0] vit_id = '0, gr_id = '0;
  logic [SC_W-1:0] vit_score = '0, gr_score = '0;
  logic [SLOT_W-1:0] rd_addr = '0;
  logic vit_ready, gr_ready, done;
  logic [ID_W-1:0] rd_id;
  logic [SC_W-1:0] rd_score;
  logic [CNT_W-1:0] count;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  active_list_merger #(.ID_W(ID_W), .SC_W(SC_W), .LIST_DEPTH(DEPTH)) i_active_list_merger (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .vit_valid(vit_valid), .vit_ready(vit_ready), .vit_id(vit_id),
    .vit_score(vit_score), .vit_end(vit_end),
    .gr_valid(gr_valid), .gr_ready(gr_ready), .gr_id(gr_id),
    .gr_score(gr_score), .gr_end(gr_end),
    .rd_addr(rd_addr), .rd_id(rd_id), .rd_score(rd_score),
    .done(done), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    summary();
  end

  // start a frame and measure the sweep length (R2)
  task automatic new_frame();
    int low = 0;
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
    while (!vit_ready && low < 2000) begin
      low++;
      @(negedge clk);
      #1;
    end
    chk("R2 sweep cycles", low, 1 << ID_W);
    chk("R2 grammar ready after sweep", int'(gr_ready), 1);
  endtask

  // present one request on a stream; called at a negedge, returns at a negedge
  task automatic send(input bit grm, input int id, input int sc);
    if (grm) begin
      gr_valid = 1'b1; gr_id = ID_W'(id); gr_score = SC_W'(sc);
    end else begin
      vit_valid = 1'b1; vit_id = ID_W'(id); vit_score = SC_W'(sc);
    end
    #1;
    while (!(grm ? gr_ready : vit_ready)) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    if (grm) gr_valid = 1'b0; else vit_valid = 1'b0;
  endtask

  task automatic close_both();
    vit_end = 1'b1; gr_end = 1'b1;
    @(negedge clk);
    vit_end = 1'b0; gr_end = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R7 done raised", int'(done), 1);
  endtask

  task automatic check_slot(input string req, input int slot, input int id, input int sc);
    rd_addr = SLOT_W'(slot);
    @(negedge clk);
    chk({req, " slot id"}, int'(rd_id), id);
    chk({req, " slot score"}, int'(rd_score), sc);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 scorer ready idle", int'(vit_ready), 0);
    chk("R1 grammar ready idle", int'(gr_ready), 0);
  endtask

  task automatic t_distinct();
    new_frame();
    send(0, 5, 100);
    send(1, 9, 200);
    send(0, 3, 50);
    close_both();
    wait_done();
    chk("R7 count distinct", int'(count), 3);
    check_slot("R3", 0, 5, 100);
    check_slot("R3", 1, 9, 200);
    check_slot("R3 R10", 2, 3, 50);
    repeat (3) @(negedge clk);
    chk("R7 done holds", int'(done), 1);
    chk("R7 count holds", int'(count), 3);
    chk("R7 scorer closed", int'(vit_ready), 0);
  endtask

  task automatic t_duplicates();
    new_frame();
    send(0, 10, 50);
    send(1, 10, 40);
    send(1, 10, 40);
    send(1, 10, 45);
    send(1, 20, 30);
    send(1, 20, 20);
    send(0, 20, 25);
    close_both();
    wait_done();
    chk("R4 count merged", int'(count), 2);
    check_slot("R4 R6", 0, 10, 40);
    check_slot("R4 R6", 1, 20, 20);
  endtask

  task automatic t_collision();
    new_frame();
    vit_valid = 1'b1; vit_id = 8'd7; vit_score = 16'd100;
    gr_valid = 1'b1; gr_id = 8'd8; gr_score = 16'd100;
    #1;
    chk("R5 scorer ready in collision", int'(vit_ready), 1);
    chk("R5 grammar held in collision", int'(gr_ready), 0);
    @(negedge clk);
    vit_valid = 1'b0;
    #1;
    chk("R5 grammar taken later", int'(gr_ready), 1);
    @(negedge clk);
    gr_valid = 1'b0;
    vit_end = 1'b1;
    @(negedge clk);
    vit_end = 1'b0;
    #1;
    chk("R7 scorer ready low after end", int'(vit_ready), 0);
    chk("R7 grammar still open", int'(gr_ready), 1);
    chk("R7 not done with one open", int'(done), 0);
    gr_end = 1'b1;
    @(negedge clk);
    gr_end = 1'b0;
    wait_done();
    chk("R5 count", int'(count), 2);
    check_slot("R5", 0, 7, 100);
    check_slot("R5", 1, 8, 100);
  endtask

  task automatic t_full();
    new_frame();
    for (int i = 0; i < DEPTH; i++) send(0, i, 1000 + i);
    send(1, 100, 1);
    send(1, 5, 7);
    close_both();
    wait_done();
    chk("R8 count saturates", int'(count), DEPTH);
    check_slot("R8 improve when full", 5, 5, 7);
    check_slot("R8 last slot kept", DEPTH - 1, DEPTH - 1, 1000 + DEPTH - 1);
  endtask

  task automatic t_new_frame_forgets();
    new_frame();
    chk("R9 count cleared", int'(count), 0);
    send(1, 5, 999);
    close_both();
    wait_done();
    chk("R9 old id listed anew", int'(count), 1);
    check_slot("R9", 0, 5, 999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_distinct();
    t_duplicates();
    t_collision();
    t_full();
    t_new_frame_forgets();
    summary();
  end
endmodule